// File: doc/BRIEF.md
# Programmable Divider and Timer

A byte-wide register block that gives a small 8-bit processor a free-running divider and a programmable interval timer. The divider advances once every 256 qualified clock cycles. The timer counter advances at one of four rates that a control field picks. When the counter passes its top value it reloads from a modulo register and sends a one-cycle interrupt request to an external interrupt controller.

Software reaches four registers through a byte read/write port, using offsets in the I/O page: divider 0x04, timer counter 0x05, modulo 0x06, control 0x07. The `tick_i` input qualifies every clock cycle. Both prescalers count only in cycles where it is high. Tie it high to run from the system clock directly.

Top module: `prog_timer`

## Requirements
- R1: The divider register (offset 0x04) increments by one after every 256 cycles with `tick_i` high, and wraps from 255 to 0.
- R2: Any write to offset 0x04 sets the divider to 0, whatever the data byte is.
- R3: Reads at offsets 0x04, 0x05 and 0x06 return the divider, the timer counter and the modulo register. Any offset outside 0x04..0x07 reads 0xFF.
- R4: When control bit 2 is 0, the timer counter and the timer prescale accumulator hold their values.
- R5: Control bits [1:0] select the timer period in qualified cycles: 00 gives 1024, 01 gives 16, 10 gives 64 and 11 gives 256.
- R6: When a timer period elapses and the counter is below 255, the counter increments by one.
- R7: When a period elapses with the counter at 255, the counter loads the modulo value held before that edge. `irq_o` is high for exactly the following cycle.
- R8: The timer accumulator subtracts the period instead of clearing. Excess count left after a switch to a shorter period fires one increment per qualified cycle until the excess falls below the period.
- R9: Only control bits [2:0] are writable. A read at offset 0x07 returns bits [7:3] as 1.
- R10: Reset (`rst_ni` low) clears all four registers, both prescalers and `irq_o`.
- R11: A write to the timer counter in a cycle where a period elapses loads the written byte, skips the increment or reload, and raises no interrupt.
- R12: With `tick_i` low, neither the divider nor the timer advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count qualifier for both prescalers |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register offset in the I/O page |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | One-cycle timer interrupt request |

## Verification
The bench tracks the timer's prescale accumulator in its own model. This lets it write the counter in exactly the cycle a period elapses. A design that let the increment win there would show the wrong count and a spurious interrupt. It switches from the 1024 period to the 16 period with a large residue. A design that cleared the accumulator would step the counter once instead of many times. It also writes nonzero data to the divider, holds `tick_i` low, and reads the control register's unused bits. These catch a divider that stores the data, prescalers that ignore the qualifier, and a control read that returns zeros in its unused bits.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ACC_W  = 10;

  localparam logic [7:0] OFS_DIV = 8'h04;
  localparam logic [7:0] OFS_CNT = 8'h05;
  localparam logic [7:0] OFS_MOD = 8'h06;
  localparam logic [7:0] OFS_CTL = 8'h07;

  typedef enum logic [1:0] {
    RATE_1024 = 2'b00,
    RATE_16   = 2'b01,
    RATE_64   = 2'b10,
    RATE_256  = 2'b11
  } rate_e;

  typedef struct packed {
    logic  en;
    rate_e rate;
  } ctl_t;

  function automatic logic [ACC_W:0] rate_period(rate_e r);
    case (r)
      RATE_16:  return (ACC_W+1)'(16);
      RATE_64:  return (ACC_W+1)'(64);
      RATE_256: return (ACC_W+1)'(256);
      default:  return (ACC_W+1)'(1024);
    endcase
  endfunction
endpackage

// File: rtl/div_unit.sv
module div_unit #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [DIV_W-1:0] div_o
);
  localparam logic [PRE_W-1:0] PRE_MAX = '1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic             carry;

  assign carry = tick_i && (pre_q == PRE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      if (tick_i) pre_q <= pre_q + 1'b1;
      if (clr_i)      div_q <= '0;
      else if (carry) div_q <= div_q + 1'b1;
    end
  end

  assign div_o = div_q;

  AST_DIV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (div_q == $past(div_q)) || (div_q == $past(div_q) + 1'b1)) // R1
    else $error("divider jumped");
  AST_DIV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> div_q == '0) // R2
    else $error("divider not cleared");
  AST_DIV_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(div_q)) // R12
    else $error("divider moved without tick");
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import prog_timer_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  rate_e rate_i,
  output logic  fire_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   acc_inc;
  logic [ACC_W:0]   period;

  assign period  = rate_period(rate_i);
  assign acc_inc = {1'b0, acc_q} + 1'b1;
  assign fire_o  = en_i && (acc_inc >= period);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else if (en_i) begin
      // keep the excess so that a shorter period still catches up
      if (fire_o) acc_q <= ACC_W'(acc_inc - period);
      else        acc_q <= acc_inc[ACC_W-1:0];
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q)) // R4
    else $error("accumulator moved while idle");
  AST_ACC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> acc_q == ACC_W'($past(acc_inc) - $past(period))) // R8
    else $error("excess not carried");
endmodule

// File: rtl/prog_timer.sv
module prog_timer
  import prog_timer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        irq_o
);
  localparam logic [DATA_W-1:0] CNT_TOP = '1;

  logic [DATA_W-1:0] div_val;
  logic [DATA_W-1:0] cnt_q, mod_q;
  ctl_t              ctl_q;
  logic              irq_q;
  logic              fire;
  logic              wr_div, wr_cnt, wr_mod, wr_ctl;

  assign wr_div = we_i && (addr_i == OFS_DIV);
  assign wr_cnt = we_i && (addr_i == OFS_CNT);
  assign wr_mod = we_i && (addr_i == OFS_MOD);
  assign wr_ctl = we_i && (addr_i == OFS_CTL);

  div_unit #(.PRE_W(8), .DIV_W(DATA_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (wr_div),
    .div_o  (div_val)
  );

  tmr_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_i && ctl_q.en),
    .rate_i (ctl_q.rate),
    .fire_o (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mod_q <= '0;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_cnt) cnt_q <= wdata_i;
      else if (fire) begin
        if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
        else begin
          cnt_q <= mod_q;
          irq_q <= 1'b1;
        end
      end
      if (wr_mod) mod_q <= wdata_i;
      if (wr_ctl) ctl_q <= ctl_t'(wdata_i[2:0]);
    end
  end

  always_comb begin
    case (addr_i)
      OFS_DIV: rdata_o = div_val;
      OFS_CNT: rdata_o = cnt_q;
      OFS_MOD: rdata_o = mod_q;
      OFS_CTL: rdata_o = {5'b11111, ctl_q};
      default: rdata_o = 8'hFF;
    endcase
  end

  assign irq_o = irq_q;

  AST_IRQ_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt_q == $past(mod_q)) // R7
    else $error("irq without reload");
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q.en && !wr_cnt) |=> $stable(cnt_q)) // R4
    else $error("counter moved while disabled");
  AST_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> (cnt_q == $past(wdata_i)) && !irq_o) // R11
    else $error("counter write lost");
  AST_CTL_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_CTL) |-> rdata_o[7:3] == 5'b11111) // R9
    else $error("control upper bits");
endmodule

// File: tb/prog_timer_test.sv
module prog_timer_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = 8'h00, wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic irq_o;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R10";

  // reference state
  int m_div, m_pre, m_cnt, m_mod, m_ctl, m_acc;
  bit m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic int period_of(int sel);
    case (sel)
      1: return 16;
      2: return 64;
      3: return 256;
      default: return 1024;
    endcase
  endfunction

  function automatic int exp_read(int a);
    case (a)
      4: return m_div;
      5: return m_cnt;
      6: return m_mod;
      7: return 8'hF8 | m_ctl;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit fires_next(bit tk);
    return tk && m_ctl[2] && (m_acc + 1 >= period_of(m_ctl & 3));
  endfunction

  task automatic model_step(bit we, int a, int d, bit tk);
    bit f = 0;
    bit carry = 0;
    int p = period_of(m_ctl & 3);
    if (tk && m_ctl[2]) begin
      if (m_acc + 1 >= p) begin m_acc = m_acc + 1 - p; f = 1; end
      else m_acc = m_acc + 1;
    end
    m_irq = 0;
    if (we && a == 5) m_cnt = d;
    else if (f) begin
      if (m_cnt < 255) m_cnt++;
      else begin m_cnt = m_mod; m_irq = 1; end
    end
    if (tk) begin
      carry = (m_pre == 255);
      m_pre = (m_pre + 1) % 256;
    end
    if (we && a == 4) m_div = 0;
    else if (carry) m_div = (m_div + 1) % 256;
    if (we && a == 6) m_mod = d;
    if (we && a == 7) m_ctl = d & 7;
  endtask

  task automatic check(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(bit we, int a, int d, bit tk);
    @(negedge clk);
    we_i = we; addr_i = 8'(a); wdata_i = 8'(d); tick_i = tk;
    @(posedge clk);
    #1;
    model_step(we, a, d, tk);
    check("irq", int'(irq_o), int'(m_irq));
    check($sformatf("rdata@%0h", a), int'(rdata_o), exp_read(a));
  endtask

  task automatic run(int n, int a, bit tk);
    for (int i = 0; i < n; i++) step(0, a, 0, tk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    m_div = 0; m_pre = 0; m_cnt = 0; m_mod = 0; m_ctl = 0; m_acc = 0; m_irq = 0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;

    cur_req = "R10";  // reset state, plus R3 R9 reads
    for (int a = 3; a <= 8; a++) step(0, a, 0, 0);

    cur_req = "R9";
    step(1, 7, 8'hF8, 0); step(0, 7, 0, 0);
    step(1, 7, 8'hFB, 0); step(0, 7, 0, 0);
    step(1, 7, 8'h00, 0); step(0, 7, 0, 0);

    cur_req = "R1";
    run(600, 4, 1);
    cur_req = "R2";
    step(1, 4, 8'hA5, 1); step(0, 4, 0, 1);

    cur_req = "R12";
    step(1, 7, 8'h05, 0);
    run(300, 5, 0); run(5, 4, 0);

    cur_req = "R5";
    for (int s = 0; s < 4; s++) begin
      step(1, 6, 0, 1); step(1, 5, 0, 1);
      step(1, 7, 4 | s, 1);
      run(1100, 5, 1);
    end

    cur_req = "R6 R7";
    step(1, 7, 8'h05, 1); step(1, 6, 8'hC0, 1); step(1, 5, 8'hFD, 1);
    run(60, 5, 1);

    cur_req = "R11";
    step(1, 5, 8'hFF, 1);
    while (!fires_next(1)) step(0, 5, 0, 1);
    step(1, 5, 8'h33, 1);
    run(20, 5, 1);

    cur_req = "R8";
    step(1, 7, 8'h04, 1); step(1, 5, 8'h00, 1);
    run(900, 6, 1);
    step(1, 7, 8'h05, 1);
    run(80, 5, 1);

    cur_req = "R4";
    step(1, 7, 8'h01, 1);
    run(1500, 5, 1);
    step(1, 7, 8'h05, 1); run(40, 5, 1);

    cur_req = "R3 random";
    for (int i = 0; i < 20000; i++) begin
      int r = $urandom_range(0, 99);
      int a = $urandom_range(3, 8);
      bit tk = ($urandom_range(0, 7) != 0);
      if (r < 3) step(1, 7, $urandom_range(0, 255), tk);
      else if (r < 6) step(1, $urandom_range(4, 6), $urandom_range(0, 255), tk);
      else step(0, a, 0, tk);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule